// File: doc/BRIEF.md
# Expandable 3-to-8 line decoder

The block turns a three-bit binary select into eight mutually exclusive active-low lines. A line can go low only when all three gating enables are asserted. One enable is active high and the other two are active low. Because the enables have mixed polarity, the same cell serves two further uses. Fed with a serial bit on one active-low enable, it acts as a 1-to-8 demultiplexer. Combined with copies of itself and a single inversion of the upper address bits, it becomes a wider decoder.

The top module carries two independent groups of ports. The first group is one decode cell with its own select, three enables and eight outputs. The second group is a 5-to-32 decoder built from four cells. The upper two address bits pick one cell, in ascending order: 0 selects outputs 0..7 and 3 selects outputs 24..31. The lower three bits drive every cell's select in parallel. One global active-low enable reaches every cell of the wide decoder, so it can blank all 32 lines at once, or carry serial data for 1-to-32 distribution.

The design is purely combinational. It has no clock, no reset and no state. Unused enables are expected to be tied to their asserted levels.

Top module: `dec_expand_top`

## Requirements
- R1: The select is binary weighted, with `sel[2]` most significant and `sel[0]` least. For example, `sel` = 3'b100 drives line 4, that is `y_n[4]`, low.
- R2: At most one of the eight cell outputs `y_n` is low, for every input combination.
- R3: All eight `y_n` lines are high unless `en_hi` = 1, `en_lo_a_n` = 0 and `en_lo_b_n` = 0.
- R4: When the cell is enabled, `y_n[sel]` is low and the other seven lines are high.
- R5: Demultiplexer use: with `en_hi` = 1 and `en_lo_b_n` = 0 held as strobes, `y_n[sel]` equals the data bit applied on `en_lo_a_n`, and all other lines stay high.
- R6: When `wide_en_n` = 0, only `wide_y_n[k]` is low, where k = `wide_addr[4:3]`*8 + `wide_addr[2:0]`.
- R7: When `wide_en_n` = 1, all 32 `wide_y_n` lines are high, whatever the address.
- R8: At most one of the 32 `wide_y_n` lines is low, for every input combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 3 | Binary select of the single cell |
| en_hi | input | 1 | Active-high enable of the single cell |
| en_lo_a_n | input | 1 | First active-low enable; serves as the data input in demultiplexer use |
| en_lo_b_n | input | 1 | Second active-low enable |
| y_n | output | 8 | Active-low decoded lines of the single cell |
| wide_addr | input | 5 | Address of the 32-line decoder; bits 4:3 pick the cell, bits 2:0 pick the line |
| wide_en_n | input | 1 | Global active-low enable routed into every cell of the wide decoder |
| wide_y_n | output | 32 | Active-low decoded lines of the wide decoder |

## Verification
The bench builds the block with its default sizes: a three-bit select and two bank bits, which give four cells. These sizes keep the whole input space small enough to cover exhaustively. All eight enable combinations are crossed with all eight selects, and every line is compared and checked for one-cold behaviour. Every one of the 32 wide addresses is applied both with the global enable low and with it high. A separate pass toggles the data bit while the strobes are held, which covers demultiplexer use on every line.

// File: rtl/dec_pkg.sv
package dec_pkg;
    // select width of one decode cell and its derived line count
    localparam int SEL_W  = 3;
    localparam int OUT_N  = 1 << SEL_W;
    // bank bits of the wide decoder; the steering scheme uses one
    // active-high and one active-low cell enable, so two bits
    localparam int BANK_W = 2;
    localparam int BANKS  = 1 << BANK_W;
    localparam int WIDE_W = SEL_W + BANK_W;
    localparam int WIDE_N = OUT_N * BANKS;

    // the three gating enables of one cell
    typedef struct packed {
        logic hi;      // active high
        logic lo_a_n;  // active low, data input in demultiplexer use
        logic lo_b_n;  // active low
    } dec_en_t;
endpackage

// File: rtl/dec_cell.sv
module dec_cell
    import dec_pkg::*;
#(
    parameter int W = SEL_W,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] sel,
    input  dec_en_t      en,
    output logic [N-1:0] y_n
);
    logic gate_ok;

    // all three enables must sit at their asserted levels
    assign gate_ok = en.hi & ~en.lo_a_n & ~en.lo_b_n;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign y_n[g] = ~(gate_ok && (sel == W'(g)));
    end
endmodule

// File: rtl/dec_bank_steer.sv
module dec_bank_steer
    import dec_pkg::*;
(
    input  logic [BANK_W-1:0]  bank_addr,
    input  logic               glob_en_n,
    output dec_en_t [BANKS-1:0] bank_en
);
    logic [BANK_W-1:0] bank_inv;

    // the single shared inversion of the upper address bits
    assign bank_inv = ~bank_addr;

    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        localparam logic [BANK_W-1:0] PAT = BANK_W'(k);
        // upper bit goes to the active-high enable, true or inverted
        assign bank_en[k].hi     = PAT[1] ? bank_addr[1] : bank_inv[1];
        // lower bit goes to an active-low enable, inverted or true
        assign bank_en[k].lo_b_n = PAT[0] ? bank_inv[0]  : bank_addr[0];
        // global enable shared by every cell
        assign bank_en[k].lo_a_n = glob_en_n;
    end
endmodule

// File: rtl/dec_expand_top.sv
module dec_expand_top
    import dec_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic              en_hi,
    input  logic              en_lo_a_n,
    input  logic              en_lo_b_n,
    output logic [OUT_N-1:0]  y_n,
    input  logic [WIDE_W-1:0] wide_addr,
    input  logic              wide_en_n,
    output logic [WIDE_N-1:0] wide_y_n
);
    dec_en_t              cell_en;
    dec_en_t [BANKS-1:0]  bank_en;

    assign cell_en.hi     = en_hi;
    assign cell_en.lo_a_n = en_lo_a_n;
    assign cell_en.lo_b_n = en_lo_b_n;

    dec_cell #(.W(SEL_W)) u_single (
        .sel (sel),
        .en  (cell_en),
        .y_n (y_n)
    );

    dec_bank_steer u_steer (
        .bank_addr (wide_addr[WIDE_W-1:SEL_W]),
        .glob_en_n (wide_en_n),
        .bank_en   (bank_en)
    );

    for (genvar k = 0; k < BANKS; k++) begin : g_cell
        dec_cell #(.W(SEL_W)) u_cell (
            .sel (wide_addr[SEL_W-1:0]),
            .en  (bank_en[k]),
            .y_n (wide_y_n[k*OUT_N +: OUT_N])
        );
    end
endmodule

// File: rtl/dec_expand_chk.sv
module dec_expand_chk
    import dec_pkg::*;
(
    input logic [SEL_W-1:0]  sel,
    input logic              en_hi,
    input logic              en_lo_a_n,
    input logic              en_lo_b_n,
    input logic [OUT_N-1:0]  y_n,
    input logic [WIDE_W-1:0] wide_addr,
    input logic              wide_en_n,
    input logic [WIDE_N-1:0] wide_y_n
);
    logic cell_on;
    assign cell_on = en_hi && !en_lo_a_n && !en_lo_b_n;

    always_comb begin
        p_onecold_r2: assert ($onehot0(~y_n));
        p_gate_r3: assert (cell_on || (y_n == '1));
        p_index_r4: assert (!cell_on || !y_n[sel]);
        p_wide_index_r6: assert (wide_en_n || !wide_y_n[wide_addr]);
        p_wide_blank_r7: assert (!wide_en_n || (wide_y_n == '1));
        p_wide_onecold_r8: assert ($onehot0(~wide_y_n));
    end
endmodule

bind dec_expand_top dec_expand_chk u_chk (
    .sel       (sel),
    .en_hi     (en_hi),
    .en_lo_a_n (en_lo_a_n),
    .en_lo_b_n (en_lo_b_n),
    .y_n       (y_n),
    .wide_addr (wide_addr),
    .wide_en_n (wide_en_n),
    .wide_y_n  (wide_y_n)
);

// File: tb/tb_dec_expand_top.sv
module tb_dec_expand_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  sel = 0;
    logic        en_hi = 0;
    logic        en_lo_a_n = 1;
    logic        en_lo_b_n = 1;
    logic [7:0]  y_n;
    logic [4:0]  wide_addr = 0;
    logic        wide_en_n = 1;
    logic [31:0] wide_y_n;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0]  ey;
        logic [31:0] ew;
        string       tag_c;
        string       tag_w;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_expand_top dut (
        .sel       (sel),
        .en_hi     (en_hi),
        .en_lo_a_n (en_lo_a_n),
        .en_lo_b_n (en_lo_b_n),
        .y_n       (y_n),
        .wide_addr (wide_addr),
        .wide_en_n (wide_en_n),
        .wide_y_n  (wide_y_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lows(input logic [31:0] v);
        int c = 0;
        for (int i = 0; i < 32; i++) if (!v[i]) c++;
        return c;
    endfunction

    // driver: applies one stimulus and pushes its expected item
    task automatic apply(input logic [2:0] s, input logic h, input logic a, input logic b,
                         input logic [4:0] wa, input logic we,
                         input string tc, input string tw);
        item_t it;
        @(posedge clk);
        sel = s; en_hi = h; en_lo_a_n = a; en_lo_b_n = b;
        wide_addr = wa; wide_en_n = we;
        it.ey = (h && !a && !b) ? ~(8'b1 << s) : 8'hFF;
        it.ew = (!we) ? ~(32'b1 << (int'(wa[4:3]) * 8 + int'(wa[2:0]))) : 32'hFFFF_FFFF;
        it.tag_c = tc;
        it.tag_w = tw;
        sb.push_back(it);
    endtask

    // monitor: compares at the falling edge, away from stimulus changes
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag_c, {24'h0, y_n}, {24'h0, it.ey});
            check("R2 one-cold cell", lows({24'hFFFFFF, y_n}) <= 1, 1);
            check(it.tag_w, wide_y_n, it.ew);
            check("R8 one-cold wide", lows(wide_y_n) <= 1, 1);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 0;
        // quiescent state: everything deasserted
        apply(3'd0, 1'b0, 1'b1, 1'b1, 5'd0, 1'b1, "R3 idle state", "R7 idle state");
        // exhaustive enable x select sweep
        for (int e = 0; e < 8; e++) begin
            for (int s = 0; s < 8; s++) begin
                logic on;
                string tc;
                on = (e == 3'b100);
                if (!on) tc = "R3 disabled";
                else if (s == 4) tc = "R1 weight";
                else tc = "R4 enabled";
                apply(3'(s), e[2], e[1], e[0], {e[1:0], 3'(s)}, e[2],
                      tc, e[2] ? "R7 blanked" : "R6 wide index");
            end
        end
        // demultiplexer: data on en_lo_a_n, strobes held
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                apply(3'(s), 1'b1, d[0], 1'b0, {2'(s % 4), 3'(7 - s)}, d[0],
                      "R5 demux", d[0] ? "R7 serial high" : "R6 serial low");
            end
        end
        // every wide address, enabled then blanked
        for (int w = 0; w < 32; w++) begin
            apply(3'(w), 1'b1, 1'b0, 1'b0, 5'(w), 1'b0, "R4 enabled", "R6 wide index");
            apply(3'(w), 1'b0, 1'b0, 1'b0, 5'(w), 1'b1, "R3 disabled", "R7 blanked");
        end
        @(posedge clk);
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule